// File: doc/BRIEF.md
# Bus Clock Enable Divider Set

This block turns one selected source clock into three related bus rates: a main fast rate, a medium rate and a slow peripheral rate. Each rate appears as a one-cycle enable pulse in the common reference clock domain. The two candidate sources come in as tick strobes in that same domain, and a select bit in the configuration word picks one of them. Downstream logic gates its registers with these enables instead of running on separately divided clocks.

The main rate divides the selected source ticks by a 5-bit count plus one. The medium and slow rates do not have their own dividers. Each one counts main pulses, using a restricted power-of-two ratio code, so every medium or slow pulse falls in the same cycle as a main pulse. The medium code is direct-encoded and one of its values is illegal. The slow code is log-encoded and only its lower half is legal.

A new configuration word is written at any time and held pending. It takes effect only at the next common wrap, which is the cycle in which all three counters finish together. Illegal ratio codes are reported and run as a ratio of one.

Top module: `bcd_bus_clk_gen`

## Requirements
- R1: While `rst_n` is low, `main_en`, `med_en`, `slow_en` and `code_err` are all 0.
- R2: Bit 15 of the configuration word picks the source. When it is 0, `src0_tick` is counted. When it is 1, `src1_tick` is counted and `src0_tick` is ignored.
- R3: Bits 4:0 of the configuration word hold a main code N. `main_en` pulses once every N+1 selected source ticks, for every N from 0 to 31.
- R4: `med_en` and `slow_en` are only ever high in cycles where `main_en` is also high.
- R5: Bits 9:8 hold the medium code, direct-encoded. Codes 0, 1 and 3 give one `med_en` pulse every 1, 2 and 4 `main_en` pulses.
- R6: Bits 14:12 hold the slow code, log-encoded. Codes 0, 1, 2 and 3 give one `slow_en` pulse every 1, 2, 4 and 8 `main_en` pulses.
- R7: Medium code 2 and slow codes 4 to 7 are illegal. An illegal code runs as ratio 1, and `code_err` is high while an active setting holds one.
- R8: A word written with `cfg_we` takes effect only at the next common wrap. That wrap is the cycle that makes `main_en`, `med_en` and `slow_en` pulse together. Until that cycle, all enables follow the previous settings.
- R9: After reset the active word is all zeros: `src0_tick` is selected and all three enables pulse on every `src0_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock in which the source ticks arrive |
| rst_n | input | 1 | Asynchronous active-low reset |
| src0_tick | input | 1 | Tick strobe of the first source clock |
| src1_tick | input | 1 | Tick strobe of the second source clock |
| cfg_we | input | 1 | Loads `cfg_word` into the pending setting |
| cfg_word | input | 16 | Configuration word: select, slow, medium and main codes |
| main_en | output | 1 | Main-rate enable pulse |
| med_en | output | 1 | Medium-rate enable pulse |
| slow_en | output | 1 | Slow-rate enable pulse |
| code_err | output | 1 | The active word holds an illegal ratio code |

## Verification
The bench uses the default field widths: a 5-bit main code, a 2-bit direct medium code and a 3-bit log slow code. With these widths the largest main count (31) can be reached, as can every legal and illegal ratio code. `src0_tick` is held high and `src1_tick` fires every third cycle. Because the two sources give different tick periods, switching the source visibly stretches the pulse spacing. Counting pulses over windows that start at a common wrap makes every expected count exact. The deferred-load test writes a new word in the cycle right after a wrap, so the window in which the old settings must still hold is as long as possible.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    parameter int CFG_W    = 16;
    parameter int SEL_BIT  = 15;
    parameter int SLOW_LSB = 12;
    parameter int SLOW_W   = 3;
    parameter int MED_LSB  = 8;
    parameter int MED_W    = 2;
    parameter int MAIN_LSB = 0;
    parameter int MAIN_W   = 5;
    parameter int LOG_MAX  = 3;

    typedef enum logic {
        ENC_DIRECT = 1'b0,
        ENC_LOG    = 1'b1
    } ratio_enc_e;

    typedef struct packed {
        logic              sel;
        logic [SLOW_W-1:0] slow;
        logic [MED_W-1:0]  med;
        logic [MAIN_W-1:0] main;
    } clk_cfg_t;

    function automatic clk_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        clk_cfg_t c;
        c.sel  = w[SEL_BIT];
        c.slow = w[SLOW_LSB +: SLOW_W];
        c.med  = w[MED_LSB +: MED_W];
        c.main = w[MAIN_LSB +: MAIN_W];
        return c;
    endfunction

endpackage

// File: rtl/bcd_main_div.sv
module bcd_main_div #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] code,
    output logic         term
);

    logic [W-1:0] cnt_d, cnt_q;

    assign term = tick && (cnt_q == code);

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d = term ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/bcd_ratio_stage.sv
module bcd_ratio_stage
    import bcd_pkg::*;
#(
    parameter int         CODE_W  = 2,
    parameter ratio_enc_e ENC     = ENC_DIRECT,
    parameter int         LOG_LIM = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [CODE_W-1:0] code,
    output logic              term,
    output logic              illegal
);

    localparam int MAX_RATIO = (ENC == ENC_DIRECT) ? (1 << CODE_W) : (1 << LOG_LIM);
    localparam int CNT_RAW   = $clog2(MAX_RATIO);
    localparam int CNT_W     = (CNT_RAW < 1) ? 1 : CNT_RAW;

    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    generate
        if (ENC == ENC_DIRECT) begin : g_direct
            logic [CODE_W:0] code_ext;
            logic [CODE_W:0] code_inc;
            always_comb begin
                code_ext = {1'b0, code};
                code_inc = code_ext + 1'b1;
                illegal  = (code_inc & code_ext) != '0;
                lim      = illegal ? '0 : CNT_W'(code);
            end
        end else begin : g_log
            always_comb begin
                illegal = (32'(code) > LOG_LIM);
                lim     = illegal ? '0 : CNT_W'((32'd1 << code) - 32'd1);
            end
        end
    endgenerate

    assign term = adv && (cnt_q == lim);

    always_comb begin
        cnt_d = cnt_q;
        if (adv) begin
            cnt_d = term ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/bcd_bus_clk_gen.sv
module bcd_bus_clk_gen
    import bcd_pkg::*;
#(
    parameter int WORD_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src0_tick,
    input  logic              src1_tick,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              main_en,
    output logic              med_en,
    output logic              slow_en,
    output logic              code_err
);

    typedef struct packed {
        clk_cfg_t          act;
        logic [CFG_W-1:0]  pend;
        logic              main_en;
        logic              med_en;
        logic              slow_en;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic sel_tick;
    logic main_term, med_term, slow_term;
    logic med_ill, slow_ill;
    logic wrap;

    assign sel_tick = st_q.act.sel ? src1_tick : src0_tick;

    bcd_main_div #(
        .W(MAIN_W)
    ) main_div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sel_tick),
        .code  (st_q.act.main),
        .term  (main_term)
    );

    bcd_ratio_stage #(
        .CODE_W  (MED_W),
        .ENC     (ENC_DIRECT),
        .LOG_LIM (LOG_MAX)
    ) med_stage_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (main_term),
        .code    (st_q.act.med),
        .term    (med_term),
        .illegal (med_ill)
    );

    bcd_ratio_stage #(
        .CODE_W  (SLOW_W),
        .ENC     (ENC_LOG),
        .LOG_LIM (LOG_MAX)
    ) slow_stage_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (main_term),
        .code    (st_q.act.slow),
        .term    (slow_term),
        .illegal (slow_ill)
    );

    assign wrap = main_term && med_term && slow_term;

    always_comb begin
        st_d         = st_q;
        st_d.main_en = main_term;
        st_d.med_en  = med_term;
        st_d.slow_en = slow_term;
        if (wrap) begin
            st_d.act = unpack_cfg(st_q.pend);
        end
        if (cfg_we) begin
            st_d.pend = CFG_W'(cfg_word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_en  = st_q.main_en;
    assign med_en   = st_q.med_en;
    assign slow_en  = st_q.slow_en;
    assign code_err = med_ill || slow_ill;

endmodule

// File: rtl/bcd_bus_clk_gen_chk.sv
module bcd_bus_clk_gen_chk
    import bcd_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     src0_tick,
    input logic     src1_tick,
    input logic     main_en,
    input logic     med_en,
    input logic     slow_en,
    input logic     code_err,
    input logic     wrap,
    input clk_cfg_t act
);

    AST_MED_WITH_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        med_en |-> main_en); // R4

    AST_SLOW_WITH_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        slow_en |-> main_en); // R4

    AST_MAIN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_en) |-> $past(src0_tick || src1_tick)); // R3

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act)); // R8

    AST_ERR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_err) |-> $past(wrap)); // R7

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!main_en && !med_en && !slow_en && !code_err); // R1
        end
    end

endmodule

bind bcd_bus_clk_gen bcd_bus_clk_gen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src0_tick (src0_tick),
    .src1_tick (src1_tick),
    .main_en   (main_en),
    .med_en    (med_en),
    .slow_en   (slow_en),
    .code_err  (code_err),
    .wrap      (wrap),
    .act       (st_q.act)
);

// File: tb/bcd_bus_clk_gen_tb_top.sv
module bcd_bus_clk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src0_tick = 1'b1;
    logic        src1_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        main_en, med_en, slow_en, code_err;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int ph = 0;

    always #10 clk = ~clk;

    bcd_bus_clk_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src0_tick (src0_tick),
        .src1_tick (src1_tick),
        .cfg_we    (cfg_we),
        .cfg_word  (cfg_word),
        .main_en   (main_en),
        .med_en    (med_en),
        .slow_en   (slow_en),
        .code_err  (code_err)
    );

    always @(negedge clk) begin
        ph = (ph == 2) ? 0 : ph + 1;
        src1_tick <= (ph == 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic sel, input int slow, input int med, input int n);
        logic [15:0] w;
        w = '0;
        w[15]    = sel;
        w[14:12] = 3'(slow);
        w[9:8]   = 2'(med);
        w[4:0]   = 5'(n);
        return w;
    endfunction

    task automatic cfg_write(input logic [15:0] w);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_word = w;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic align_wrap(input string tag);
        int waited = 0;
        @(negedge clk);
        while (!(main_en && med_en && slow_en) && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " common wrap found"}, int'(waited < 2000), 1);
    endtask

    // Counts pulses over a window starting at a common wrap.
    task automatic run_case(input string tag, input logic [15:0] w, input int pm,
                            input int rm, input int rs, input int exp_err, input int k);
        int win, c_main, c_med, c_slow, c_orph;
        cfg_write(w);
        repeat (1000) @(negedge clk);
        align_wrap(tag);
        chk({tag, " code_err"}, int'(code_err), exp_err);
        win = k * pm * ((rm > rs) ? rm : rs);
        c_main = 0; c_med = 0; c_slow = 0; c_orph = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            c_main += int'(main_en);
            c_med  += int'(med_en);
            c_slow += int'(slow_en);
            if ((med_en || slow_en) && !main_en) c_orph++;
        end
        chk({tag, " main pulses"}, c_main, win / pm);
        chk({tag, " medium pulses"}, c_med, win / (pm * rm));
        chk({tag, " slow pulses"}, c_slow, win / (pm * rs));
        chk({tag, " R4 enables outside main"}, c_orph, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R1 enables in reset", int'(main_en || med_en || slow_en || code_err), 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9 default all enables", int'(main_en && med_en && slow_en), 1);
        end
        chk("R9 default code_err", int'(code_err), 0);
    endtask

    task automatic t_deferred;
        int c_main, c_slow;
        run_case("R6 slow 8 base", mk(1'b0, 3, 0, 0), 1, 1, 8, 0, 2);
        align_wrap("R8");
        cfg_we   = 1'b1;
        cfg_word = mk(1'b0, 0, 0, 1);
        c_main = 0; c_slow = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            c_main += int'(main_en);
            c_slow += int'(slow_en);
        end
        chk("R8 old main rate held", c_main, 7);
        chk("R8 no early slow pulse", c_slow, 0);
        @(negedge clk);
        chk("R8 wrap on old schedule", int'(main_en && slow_en), 1);
        @(negedge clk);
        chk("R8 new ratio gap", int'(main_en), 0);
        @(negedge clk);
        chk("R8 new ratio pulse", int'(main_en), 1);
    endtask

    initial begin
        t_reset();
        run_case("R3 R5 R6 src0 n4", mk(1'b0, 2, 1, 4), 5, 2, 4, 0, 2);
        run_case("R2 R5 R6 src1 n1", mk(1'b1, 3, 3, 1), 6, 4, 8, 0, 2);
        run_case("R3 max main code", mk(1'b0, 1, 0, 31), 32, 1, 2, 0, 2);
        run_case("R7 illegal medium", mk(1'b0, 0, 2, 2), 3, 1, 1, 1, 4);
        run_case("R7 illegal slow", mk(1'b0, 6, 3, 0), 1, 4, 1, 1, 3);
        run_case("R7 legal again", mk(1'b1, 1, 1, 0), 3, 2, 2, 0, 3);
        t_deferred();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule